// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a serial configuration store. It holds a bit image that is fixed when the design is elaborated. It shifts that image out one bit per rising edge of a shift clock, starting at address zero. Its usual load is an FPGA that samples the data line on each rising shift-clock edge. An address counter advances once per counted edge. The counter moves only while the enable pin is active, chip select is low and the image has not yet been fully sent. When the enable pin is inactive, the counter is cleared and the stream starts over.

Several readers can form a chain. The cascade output of one reader drives the chip select of the next one. When the enable pin becomes active, each reader looks at its chip select and takes one of two roles:
- A reader that sees chip select low becomes the master. It generates the shift clock by dividing the system clock, and it keeps that clock running for a set number of edges that covers the whole chain.
- A reader that sees chip select high becomes a subsequent reader. It synchronises the master's clock and counts its rising edges.

A power-up indicator stays low during reset and for a fixed settling time afterwards.

Top module: `cfg_stream_reader`

## Requirements
- R1: Bit a of the image equals the parity (XOR) of bits [23:16] of (a*40503 + SEED) mod 2^32. Bits are sent in ascending address order from address 0.
- R2: After each counted rising shift-clock edge, `dout` shows the next image bit. It changes no later than 3 system clocks after the shift-clock rise, so the value at the rise is the bit for the current address.
- R3: The counter advances only while the enable is active, `sel_n_i` is low and the counter is below DEPTH. After DEPTH bits, further edges leave it unchanged.
- R4: While the enable is inactive, the counter is held at zero. Once the enable returns, the stream restarts from address 0.
- R5: `dout_oe` is high only when, in the previous cycle, the enable was active, `sel_n_i` was low and the image was not finished.
- R6: When the enable becomes active (after ready), the role is latched from `sel_n_i`. Low selects master (`sclk_oe`=1); high selects subsequent (`sclk_oe`=0, and `sclk_o` stays low).
- R7: A running master drives `sclk_o` with a period of 2*HALF system clocks. It produces exactly CHAIN_BITS rising edges per run, and holds `sclk_o` low when not permitted to run.
- R8: `casc_n_o` is high after reset and while the counter is cleared. It is low from the point the counter reaches DEPTH.
- R9: `ready_o` is low during `rst` and for POR_CYCLES clocks after it. No clock, data or cascade activity happens before `ready_o` is high.
- R10: With OE_HIGH=1 the enable is active when `oe_i`=1. With OE_HIGH=0 it is active when `oe_i`=0.
- R11: A subsequent reader counts each rising edge of `sclk_i` exactly once, using a two-flop synchroniser and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| oe_i | input | 1 | Output enable / counter reset, polarity set by OE_HIGH |
| sel_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | External shift clock (subsequent role) |
| sclk_o | output | 1 | Generated shift clock (master role) |
| sclk_oe | output | 1 | High when this reader drives the shift clock |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Data driver enable |
| casc_n_o | output | 1 | Active-low cascade select to the next reader |
| ready_o | output | 1 | Power-up complete |

## Verification
The bench chains a master and a subsequent reader and checks the merged data line at every shift-clock rise. It checks that the line carries both images in order and has exactly one driver. A reader that passed control one edge too early or too late would corrupt the bit at the hand-off or leave two drivers on the line. The bench then drops the enable in mid-stream and checks that the next bit is address 0. It also checks that the total number of rising edges equals the chain length, so an off-by-one in the master's edge budget shows up as an extra or missing edge. A separate master built with the inverted enable polarity checks that the polarity option controls both reset and enable.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic {
    ROLE_SUB    = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  // image content: parity of a hashed slice of the address
  function automatic logic img_bit(input logic [31:0] seed, input logic [31:0] addr);
    logic [31:0] h;
    h = addr * 32'd40503 + seed;
    return ^h[23:16];
  endfunction

endpackage

// File: rtl/cfg_por.sv
module cfg_por #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic ready_o
);
  localparam int W = (POR_CYCLES < 2) ? 1 : $clog2(POR_CYCLES);
  localparam logic [W-1:0] LAST = W'(POR_CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (cnt == LAST) ready_o <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int HALF       = 4,
  parameter int CHAIN_BITS = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o
);
  localparam int HW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam int EW = $clog2(CHAIN_BITS + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HALF - 1);
  localparam logic [EW-1:0] E_ALL  = EW'(CHAIN_BITS);

  logic [HW-1:0] hc;
  logic [EW-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk_o <= 1'b0;
      hc     <= '0;
      sent   <= '0;
    end else if (hc == H_LAST) begin
      hc <= '0;
      if (sclk_o) begin
        sclk_o <= 1'b0;
      end else if (sent != E_ALL) begin
        sclk_o <= 1'b1;
        sent   <= sent + 1'b1;
      end
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], lvl_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
  import cfg_stream_pkg::*;
#(
  parameter int          DEPTH = 2048,
  parameter logic [31:0] SEED  = 32'h1,
  localparam int         AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = img_bit(SEED, 32'(i));
  end

  always_ff @(posedge clk) begin
    if (int'(rd_addr) < DEPTH) rd_bit <= mem[rd_addr];
    else                       rd_bit <= 1'b0;
  end
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfg_stream_pkg::*;
#(
  parameter int          DEPTH      = 2048,
  parameter logic [31:0] SEED       = 32'h1,
  parameter int          HALF       = 4,
  parameter int          CHAIN_BITS = DEPTH,
  parameter int          POR_CYCLES = 16,
  parameter bit          OE_HIGH    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_i,
  input  logic sel_n_i,
  input  logic sclk_i,
  output logic sclk_o,
  output logic sclk_oe,
  output logic dout,
  output logic dout_oe,
  output logic casc_n_o,
  output logic ready_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] C_END = CW'(DEPTH);

  logic          oe_act, arm, arm_q, run, rise, step, sclk_int, lvl;
  role_e         role, role_d;
  logic [CW-1:0] cnt, cnt_d;

  cfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .ready_o(ready_o)
  );

  assign oe_act = OE_HIGH ? oe_i : ~oe_i;
  assign arm    = ready_o & oe_act;

  always_comb begin
    role_d = role;
    if (arm && !arm_q) role_d = sel_n_i ? ROLE_SUB : ROLE_MASTER;
  end

  assign run = arm & (role_d == ROLE_MASTER) & ~sel_n_i;

  cfg_sclk_gen #(.HALF(HALF), .CHAIN_BITS(CHAIN_BITS)) u_gen (
    .clk(clk), .rst(rst), .run(run), .sclk_o(sclk_int)
  );

  // master counts its own clock through the same path as a follower
  assign lvl = (role == ROLE_MASTER) ? sclk_int : sclk_i;

  cfg_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .lvl_i(lvl), .rise_o(rise)
  );

  assign step = rise & arm & ~sel_n_i & (cnt != C_END);

  always_comb begin
    if (!arm)      cnt_d = '0;
    else if (step) cnt_d = cnt + 1'b1;
    else           cnt_d = cnt;
  end

  cfg_bit_store #(.DEPTH(DEPTH), .SEED(SEED)) u_store (
    .clk(clk), .rd_addr(cnt_d[AW-1:0]), .rd_bit(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q    <= 1'b0;
      role     <= ROLE_SUB;
      cnt      <= '0;
      casc_n_o <= 1'b1;
      dout_oe  <= 1'b0;
      sclk_oe  <= 1'b0;
    end else begin
      arm_q    <= arm;
      role     <= role_d;
      cnt      <= cnt_d;
      casc_n_o <= (cnt_d != C_END);
      dout_oe  <= arm & ~sel_n_i & (cnt_d != C_END);
      sclk_oe  <= (role_d == ROLE_MASTER);
    end
  end

  assign sclk_o = sclk_int;
endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
  parameter bit OE_HIGH = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic oe_i,
  input logic sel_n_i,
  input logic sclk_o,
  input logic sclk_oe,
  input logic dout_oe,
  input logic casc_n_o,
  input logic ready_o
);
  logic arm_now;
  assign arm_now = ready_o & (OE_HIGH ? oe_i : ~oe_i);

  a_r9_quiet_until_ready: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (!dout_oe && !sclk_o && casc_n_o));

  a_r5_oe_needs_sel: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(!sel_n_i && arm_now));

  a_r4_idle_clears: assert property (@(posedge clk) disable iff (rst)
    $past(!arm_now) |-> (!sclk_o && !dout_oe && casc_n_o));

  a_r8_casc_holds: assert property (@(posedge clk) disable iff (rst)
    (!casc_n_o && arm_now) |=> !casc_n_o);

  a_r6_sub_no_clock: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe |-> !sclk_o);

  a_r7_clk_needs_sel: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $past(!sel_n_i && arm_now));
endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.OE_HIGH(OE_HIGH)) u_chk (
  .clk(clk), .rst(rst), .oe_i(oe_i), .sel_n_i(sel_n_i), .sclk_o(sclk_o),
  .sclk_oe(sclk_oe), .dout_oe(dout_oe), .casc_n_o(casc_n_o), .ready_o(ready_o)
);

// File: tb/sim_cfg_stream_reader.sv
module sim_cfg_stream_reader;
  localparam int D     = 64;
  localparam int LIMIT = 20000;

  logic clk = 0, rst = 1, oe = 0;
  always #2 clk = ~clk;

  logic s0, s0oe, d0, d0oe, c0, r0;
  logic s1, s1oe, d1, d1oe, c1, r1;
  logic s2, s2oe, d2, d2oe, c2, r2;

  cfg_stream_reader #(.DEPTH(D), .SEED(32'd1), .HALF(4), .CHAIN_BITS(2*D)) u0 (
    .clk(clk), .rst(rst), .oe_i(oe), .sel_n_i(1'b0), .sclk_i(1'b0),
    .sclk_o(s0), .sclk_oe(s0oe), .dout(d0), .dout_oe(d0oe), .casc_n_o(c0), .ready_o(r0));

  cfg_stream_reader #(.DEPTH(D), .SEED(32'd77), .HALF(4), .CHAIN_BITS(2*D)) u1 (
    .clk(clk), .rst(rst), .oe_i(oe), .sel_n_i(c0), .sclk_i(s0),
    .sclk_o(s1), .sclk_oe(s1oe), .dout(d1), .dout_oe(d1oe), .casc_n_o(c1), .ready_o(r1));

  cfg_stream_reader #(.DEPTH(D), .SEED(32'd5), .HALF(4), .CHAIN_BITS(D), .OE_HIGH(1'b0)) u2 (
    .clk(clk), .rst(rst), .oe_i(~oe), .sel_n_i(1'b0), .sclk_i(1'b0),
    .sclk_o(s2), .sclk_oe(s2oe), .dout(d2), .dout_oe(d2oe), .casc_n_o(c2), .ready_o(r2));

  int tests = 0, fails = 0, cyc = 0;
  int k0 = 0, k2 = 0, rises0 = 0;
  logic p0 = 0, p2 = 0, restarted = 0;

  function automatic logic ref_bit(input int seed, input int a);
    logic [31:0] v;
    v = 32'(a) * 32'd40503 + 32'(seed);
    return ^v[23:16];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: stream position advanced on every observed clock rise
  always @(negedge clk) begin
    cyc++;
    chk(!(d0oe && d1oe), "R5 single driver", int'(d0oe) + int'(d1oe), 1);
    if (s0 && !p0) begin
      if (k0 < D) begin
        chk(d0oe && !d1oe, "R5 master drives", int'(d0oe), 1);
        chk(d0 == ref_bit(1, k0), "R1 R2 master bit", int'(d0), int'(ref_bit(1, k0)));
      end else begin
        chk(d1oe && !d0oe, "R3 R8 hand-off driver", int'(d1oe), 1);
        chk(d1 == ref_bit(77, k0 - D), "R11 follower bit", int'(d1), int'(ref_bit(77, k0 - D)));
      end
      if (restarted) begin
        chk(k0 == 0 && d0 == ref_bit(1, 0), "R4 restart at zero", k0, 0);
        restarted = 0;
      end
      k0++;
      rises0++;
    end
    if (s2 && !p2) begin
      chk(d2oe && d2 == ref_bit(5, k2), "R10 inverted enable stream", int'(d2), int'(ref_bit(5, k2)));
      k2++;
    end
    p0 = s0;
    p2 = s2;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!r0 && !d0oe && c0 && !s0, "R9 reset state", int'(r0), 0);
    chk(c1 && c2, "R8 casc high in reset", int'(c1), 1);
    @(posedge clk); #1 rst = 0;
    repeat (10) @(negedge clk);
    chk(!r0, "R9 still settling", int'(r0), 0);
    repeat (12) @(negedge clk);
    chk(r0 && r1, "R9 ready", int'(r0), 1);
    chk(!s0 && !d0oe && !s2, "R7 idle while enable inactive", int'(s0), 0);
    @(posedge clk); #1 oe = 1;
    repeat (3) @(negedge clk);
    chk(s0oe == 1, "R6 master role", int'(s0oe), 1);
    chk(s1oe == 0, "R6 subsequent role", int'(s1oe), 0);

    while (k0 < 30 && cyc < LIMIT) @(negedge clk);
    @(posedge clk); #1 oe = 0;
    repeat (3) @(negedge clk);
    chk(!d0oe && !d1oe && !s0, "R4 quiet in reset", int'(d0oe), 0);
    chk(c0 == 1, "R4 counter cleared", int'(c0), 1);
    @(posedge clk); #1;
    k0 = 0; k2 = 0; rises0 = 0; restarted = 1;
    oe = 1;

    while (k0 < 2*D && cyc < LIMIT) @(negedge clk);
    repeat (100) @(negedge clk);
    if (cyc >= LIMIT) chk(1'b0, "R7 watchdog expired", cyc, LIMIT);
    chk(rises0 == 2*D, "R7 exact edge count", rises0, 2*D);
    chk(!s0, "R7 clock parked low", int'(s0), 0);
    chk(c0 == 0 && c1 == 0, "R8 casc after full image", int'(c1), 0);
    chk(!d0oe && !d1oe, "R3 R5 no driver after end", int'(d1oe), 0);
    chk(k2 == D && c2 == 0, "R10 inverted reader finished", k2, D);
    chk(!s1, "R6 follower never clocks", int'(s1), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule